// File: doc/BRIEF.md
# XMP Frame Pair Assembler

This block sits behind an infrared bit decoder that already delivers whole 32-bit XMP frame words. Each word arrives with a one-cycle valid strobe. The block checks the word's nibble checksum and keeps the last good word as the "earlier" frame. It joins each new word with that earlier frame to form a 32-bit key scancode.

A key is reported only when two things hold together. The new word must pass its checksum. The sub-address spread across the earlier word must equal the sub-address spread across the new word.

A nibble in the new word then picks the kind of report: a fresh key press or a held-key repeat. A checksum failure raises an error strobe and forgets the earlier frame. A sub-address mismatch produces no output, but the new word is kept as the earlier frame for the next pairing. An unexpected manufacturer byte in the earlier frame only raises a warning beside the report.

Top module: `xmp_pair_assembler`

## Requirements
- R1: After reset all strobes and `warn_oem` are low, `scancode` is zero and the stored earlier frame is zero. A first frame with bits [31:28], [23:20] and [19:16] all zero therefore pairs with it.
- R2: A frame passes its checksum only when the sum, modulo 16, of its eight nibbles is zero. Bits [27:24] carry the checksum nibble. A failing frame raises `chk_err` for one cycle and gives no key or repeat report.
- R3: A frame failing its checksum clears the stored earlier frame to zero.
- R4: For a good frame, the earlier sub-address {earlier[31:28], earlier[23:20]} is compared with the new one {new[31:28], new[19:16]}. If they differ there is no report, and the new frame replaces the stored earlier frame.
- R5: On a report, `scancode` becomes {earlier[7:0], new[31:28], new[19:16], new[15:8], new[7:0]}. It holds its value in every cycle without a report.
- R6: For a good, matching frame, toggle nibble new[23:20] equal to zero gives a one-cycle `key_down`. Any nonzero toggle gives a one-cycle `key_repeat` instead.
- R7: `warn_oem` pulses together with a report when earlier[15:8] differs from 0x44. It never suppresses the report.
- R8: After a report, the new frame becomes the stored earlier frame.
- R9: All strobes appear in the cycle after the frame is accepted, last exactly one cycle, and at most one of `key_down`, `key_repeat`, `chk_err` is high at a time.
- R10: While `frame_vld` is low, `frame_word` is ignored: no strobe is raised and the stored frame is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | One-cycle strobe marking a decoded frame |
| frame_word | input | 32 | Decoded frame word, sampled with `frame_vld` |
| key_down | output | 1 | New key press strobe |
| key_repeat | output | 1 | Held-key repeat strobe |
| scancode | output | 32 | Assembled scancode, updated on each report |
| chk_err | output | 1 | Checksum failure strobe |
| warn_oem | output | 1 | Unexpected manufacturer byte, shown with a report |

## Verification
The assertions rely on a few conditions at the inputs:
- `frame_vld` and `frame_word` are driven to known values from the first clock edge.
- `frame_word` is sampled only in cycles where `frame_vld` is high.

The stimulus changes inputs only on the falling edge and holds `frame_word` at arbitrary values while `frame_vld` is low, to exercise that it is ignored. Random frames are built so that about a third carry a bad checksum and about half reuse the stored sub-address. Pairing, mismatch and clearing therefore all occur often.

// File: rtl/xmp_pair_assembler.sv
module xmp_pair_assembler #(
  parameter int          FRAME_W    = 32,
  parameter logic [7:0]  OEM_EXPECT = 8'h44
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_vld,
  input  logic [FRAME_W-1:0] frame_word,
  output logic               key_down,
  output logic               key_repeat,
  output logic [FRAME_W-1:0] scancode,
  output logic               chk_err,
  output logic               warn_oem
);
  localparam int NIBS = FRAME_W / 4;

  logic [FRAME_W-1:0] earlier;
  logic [3:0]         nib_sum;
  logic [3:0]         cs_want;
  logic               cs_ok;
  logic [7:0]         sub_old;
  logic [7:0]         sub_new;
  logic [3:0]         toggle;

  always_comb begin
    nib_sum = '0;
    for (int i = 0; i < NIBS; i++) nib_sum = nib_sum + frame_word[4*i +: 4];
  end

  assign cs_want = ~(nib_sum + 4'hF - frame_word[27:24]);
  assign cs_ok   = (cs_want == frame_word[27:24]);
  assign sub_old = {earlier[31:28], earlier[23:20]};
  assign sub_new = {frame_word[31:28], frame_word[19:16]};
  assign toggle  = frame_word[23:20];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      earlier    <= '0;
      scancode   <= '0;
      key_down   <= 1'b0;
      key_repeat <= 1'b0;
      chk_err    <= 1'b0;
      warn_oem   <= 1'b0;
    end else begin
      key_down   <= 1'b0;
      key_repeat <= 1'b0;
      chk_err    <= 1'b0;
      warn_oem   <= 1'b0;
      if (frame_vld) begin
        if (!cs_ok) begin
          earlier <= '0;
          chk_err <= 1'b1;
        end else if (sub_old != sub_new) begin
          earlier <= frame_word;
        end else begin
          earlier    <= frame_word;
          scancode   <= {earlier[7:0], sub_new, frame_word[15:0]};
          key_down   <= (toggle == 4'h0);
          key_repeat <= (toggle != 4'h0);
          warn_oem   <= (earlier[15:8] != OEM_EXPECT);
        end
      end
    end
  end
endmodule

module xmp_pair_assembler_chk #(
  parameter int FRAME_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_vld,
  input logic [FRAME_W-1:0] frame_word,
  input logic               key_down,
  input logic               key_repeat,
  input logic [FRAME_W-1:0] scancode,
  input logic               chk_err,
  input logic               warn_oem
);
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({key_down, key_repeat, chk_err}));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> !(key_down || key_repeat || chk_err || warn_oem));

  a_r5_scan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_down || key_repeat) |-> $stable(scancode));

  a_r5_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (key_down || key_repeat) |-> scancode[15:0] == $past(frame_word[15:0]));

  a_r6_press_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    key_down |-> $past(frame_word[23:20]) == 4'h0);

  a_r6_repeat_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    key_repeat |-> $past(frame_word[23:20]) != 4'h0);

  a_r7_warn_with_report: assert property (@(posedge clk) disable iff (!rst_n)
    warn_oem |-> (key_down || key_repeat));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (key_down || key_repeat || chk_err) |-> $past(frame_vld));
endmodule

bind xmp_pair_assembler xmp_pair_assembler_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_word(frame_word),
  .key_down(key_down), .key_repeat(key_repeat), .scancode(scancode),
  .chk_err(chk_err), .warn_oem(warn_oem)
);

// File: tb/xmp_pair_assembler_bench.sv
`timescale 1ns/100ps
module xmp_pair_assembler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_vld = 1'b0;
  logic [31:0] frame_word = '0;
  logic        key_down, key_repeat, chk_err, warn_oem;
  logic [31:0] scancode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xmp_pair_assembler u_xmp_pair_assembler (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_word(frame_word),
    .key_down(key_down), .key_repeat(key_repeat), .scancode(scancode),
    .chk_err(chk_err), .warn_oem(warn_oem)
  );

  // behavioural reference: checksum good when all nibbles sum to 0 mod 16
  logic [31:0] m_prev;
  logic [31:0] m_scan;
  bit m_key, m_rep, m_err, m_warn;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 0; m_scan = 0; m_key = 0; m_rep = 0; m_err = 0; m_warn = 0;
    end else begin
      m_key = 0; m_rep = 0; m_err = 0; m_warn = 0;
      if (frame_vld) begin
        int total;
        total = 0;
        for (int k = 0; k < 8; k++) total += (frame_word >> (4*k)) & 15;
        if ((total % 16) != 0) begin
          m_err = 1; m_prev = 0;
        end else if (m_prev[31:28] != frame_word[31:28] ||
                     m_prev[23:20] != frame_word[19:16]) begin
          m_prev = frame_word;
        end else begin
          m_scan = {m_prev[7:0], frame_word[31:28], frame_word[19:16], frame_word[15:0]};
          if (frame_word[23:20] == 0) m_key = 1; else m_rep = 1;
          m_warn = (m_prev[15:8] != 8'h44);
          m_prev = frame_word;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (key_down !== m_key || key_repeat !== m_rep || chk_err !== m_err ||
          warn_oem !== m_warn || scancode !== m_scan) begin
        n_bad++;
        $display("FAIL R2 R5 R6 R7 R9 model: got k%b r%b e%b w%b sc%h, expected k%b r%b e%b w%b sc%h",
                 key_down, key_repeat, chk_err, warn_oem, scancode,
                 m_key, m_rep, m_err, m_warn, m_scan);
      end
    end
  end

  function automatic logic [31:0] mk(input logic [3:0] a, input logic [3:0] t,
                                     input logic [3:0] s, input logic [7:0] hi,
                                     input logic [7:0] lo);
    int others;
    logic [3:0] cs;
    others = a + t + s + hi[7:4] + hi[3:0] + lo[7:4] + lo[3:0];
    cs = 4'((16 - (others % 16)) % 16);
    return {a, cs, t, s, hi, lo};
  endfunction

  task automatic send(input logic [31:0] w);
    frame_vld = 1; frame_word = w;
    @(negedge clk);
    frame_vld = 0; frame_word = $urandom;
  endtask

  task automatic expect_out(input string tag, input bit k, input bit r, input bit e,
                            input bit w, input logic [31:0] sc);
    n_cmp++;
    if (key_down !== k || key_repeat !== r || chk_err !== e || warn_oem !== w || scancode !== sc) begin
      n_bad++;
      $display("FAIL %s: got k%b r%b e%b w%b sc%h, expected k%b r%b e%b w%b sc%h",
               tag, key_down, key_repeat, chk_err, warn_oem, scancode, k, r, e, w, sc);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 reset state", 0, 0, 0, 0, 32'h0);
    rst_n = 1;
    @(negedge clk);
    expect_out("R1 idle after reset", 0, 0, 0, 0, 32'h0);
    send(mk(4'h0, 4'h0, 4'h0, 8'h44, 8'h11));
    expect_out("R1 pairs with zero earlier frame, R7 warn", 1, 0, 0, 1, 32'h0000_4411);
    send(mk(4'h5, 4'h0, 4'h7, 8'h44, 8'h22));
    expect_out("R4 mismatch silent", 0, 0, 0, 0, 32'h0000_4411);
    send(mk(4'h5, 4'h0, 4'h0, 8'h12, 8'h34));
    expect_out("R4 stored frame used, R5 layout", 1, 0, 0, 0, 32'h2250_1234);
    send(mk(4'h5, 4'h9, 4'h0, 8'hAB, 8'hCD));
    expect_out("R6 nonzero toggle repeats, R7", 0, 1, 0, 1, 32'h3450_ABCD);
    send(mk(4'h5, 4'h9, 4'h9, 8'h44, 8'h00) ^ 32'h1);
    expect_out("R2 checksum error", 0, 0, 1, 0, 32'h3450_ABCD);
    send(mk(4'h0, 4'h0, 4'h0, 8'h44, 8'h77));
    expect_out("R3 earlier cleared", 1, 0, 0, 1, 32'h0000_4477);
    @(negedge clk);
    expect_out("R9 strobe lasts one cycle", 0, 0, 0, 0, 32'h0000_4477);
    for (int i = 0; i < 3; i++) begin
      frame_word = $urandom;
      @(negedge clk);
      expect_out("R10 word ignored while invalid", 0, 0, 0, 0, 32'h0000_4477);
    end
    send(mk(4'h0, 4'h0, 4'h0, 8'h44, 8'h88));
    expect_out("R8 reported frame kept", 1, 0, 0, 0, 32'h7700_4488);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a, t, s;
      logic [31:0] w;
      a = $urandom; t = $urandom; s = $urandom;
      if ($urandom_range(1, 0) == 1) begin a = m_prev[31:28]; s = m_prev[23:20]; end
      if ($urandom_range(3, 0) == 0) t = 0;
      w = mk(a, t, s, $urandom_range(3, 0) == 0 ? 8'h44 : 8'($urandom), 8'($urandom));
      if ($urandom_range(2, 0) == 0) w = w ^ (32'h1 << $urandom_range(31, 0));
      frame_vld = 1; frame_word = w;
      @(negedge clk);
      frame_vld = 0; frame_word = $urandom;
      repeat ($urandom_range(2, 0)) @(negedge clk);
    end
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule